// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a programmed SDRAM mode word into the column-address stream of each read or write burst. A controller loads the 13-bit mode word with a load strobe. From then on every command strobe, with its starting column and a read/write flag, starts a burst. The block puts out one column address per clock, with a valid flag and a flag on the final beat. The controller drives the address pins from these outputs during the burst and uses the decoded CAS latency and write mode that the block also brings out.

The block supports bursts of 1, 2, 4 or 8 beats and a full-page burst. It orders the beats either by wrapping upward inside the aligned block or by XOR-interleaving. It can limit writes to a single beat. A burst ends early on a stop strobe, and a new command strobe during a burst cuts the old burst off and starts a fresh one. An illegal mode word is refused and raises a sticky error flag. Data-path timing, bus turnaround and bank state are left to other logic.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset the outputs are: valid low, CAS latency 3, single-write mode off and error flag low. The mode in force is length 1, sequential, burst write.
- R2: Mode bits [2:0] set the burst length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives a full page. A read burst yields exactly that many valid beats, and the last of them is flagged.
- R3: When mode bit 3 is 0 (sequential), beat k carries the start column plus k, wrapped inside the aligned block whose size is the burst length. Length 4 from column 1 gives 1,2,3,0.
- R4: When mode bit 3 is 1 (interleaved), beat k carries the start column XOR k. Length 8 from column 5 gives 5,4,7,6,1,0,3,2.
- R5: Mode bits [6:4] must be 011. The cas_lat output then reads 3.
- R6: Any of the following is refused: a length code of 100, 101 or 110, a latency code other than 011, or a full page combined with the interleaved type. A refused mode word sets mode_error, which stays set until reset, and the previous mode stays in force.
- R7: When mode bit 9 is 1, single_write reads 1. A write command then yields exactly one beat with last set. Reads still use the full burst length.
- R8: A full-page burst walks the 10-bit column space upward from its start, wraps from 1023 to 0, and never flags last. It runs until a stop strobe or a new command ends it.
- R9: A stop strobe during a burst drops valid at the next cycle. A stop strobe while idle has no effect. A stop strobe in the same cycle as a command strobe is overridden by the command.
- R10: A command strobe during a burst abandons the old burst. The next beat is the new start column, in the current mode.
- R11: The first beat appears in the cycle after the command strobe is sampled. Beats then follow one per cycle, and valid drops in the cycle after the last beat.
- R12: A mode load during a burst does not change the burst in flight. The new mode applies from the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_load | input | 1 | Load strobe for mode_op |
| mode_op | input | 13 | Mode word |
| cmd_start | input | 1 | Read or write command strobe; also acts as the interrupt strobe during a burst |
| cmd_write | input | 1 | 1 marks the command as a write |
| cmd_col | input | 10 | Starting column of the command |
| burst_stop | input | 1 | Ends the current burst |
| col_addr | output | 10 | Column address of the current beat |
| col_valid | output | 1 | col_addr holds a burst beat |
| col_last | output | 1 | Current beat is the final one |
| cas_lat | output | 3 | Decoded CAS latency in cycles |
| single_write | output | 1 | Single-location write mode is active |
| mode_error | output | 1 | Sticky flag for a refused mode word |

## Verification
The first beat of a burst is due one clock after the edge that samples cmd_start. Each later beat follows one clock after the one before it, and valid falls one clock after the last beat. A stop strobe clears valid one clock after it is sampled. A mode load is reflected in cas_lat, single_write and mode_error one clock later. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so every check lands exactly one register stage after its stimulus. Multi-beat checks then step forward one falling edge per beat.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    typedef struct packed {
        logic [2:0] bl;
        logic       interleave;
        logic [2:0] cas;
        logic       single_wr;
    } mode_t;

    localparam logic [2:0] CAS_CODE_3 = 3'b011;
    localparam logic [2:0] BL_PAGE    = 3'b111;

    localparam mode_t MODE_RESET = '{bl: 3'b000, interleave: 1'b0,
                                     cas: CAS_CODE_3, single_wr: 1'b0};

    function automatic logic mode_legal(input mode_t m);
        logic bl_ok;
        bl_ok = (m.bl == 3'b000) || (m.bl == 3'b001) || (m.bl == 3'b010) ||
                (m.bl == 3'b011) || (m.bl == BL_PAGE);
        return bl_ok && (m.cas == CAS_CODE_3) &&
               !((m.bl == BL_PAGE) && m.interleave);
    endfunction

endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
    import colgen_pkg::*;
#(
    parameter int OP_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [OP_W-1:0] op_i,
    output mode_t           mode_o,
    output logic            err_o
);
    localparam int BL_LSB  = 0;
    localparam int BT_BIT  = 3;
    localparam int CAS_LSB = 4;
    localparam int WM_BIT  = 9;

    typedef struct packed {
        mode_t mode;
        logic  err;
    } mreg_t;

    mreg_t st_d, st_q;
    mode_t cand;

    always_comb begin
        cand.bl         = op_i[BL_LSB +: 3];
        cand.interleave = op_i[BT_BIT];
        cand.cas        = op_i[CAS_LSB +: 3];
        cand.single_wr  = op_i[WM_BIT];
        st_d = st_q;
        if (load_i) begin
            if (mode_legal(cand)) begin
                st_d.mode = cand;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_RESET, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign err_o  = st_q.err;

    // R6
    bad_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !mode_legal(cand)) |=> (mode_o == $past(mode_o)) && err_o);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

// File: rtl/colgen_beat_ctrl.sv
module colgen_beat_ctrl
    import colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_t            mode_i,
    input  logic             go_i,
    input  logic             go_write_i,
    input  logic [COL_W-1:0] go_col_i,
    input  logic             stop_i,
    output logic             valid_o,
    output logic             last_o,
    output logic [COL_W-1:0] start_col_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] mask_o,
    output logic             interleave_o
);
    typedef struct packed {
        logic             active;
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] mask;
        logic             inter;
        logic             full;
    } bst_t;

    bst_t s_d, s_q;
    logic [COL_W-1:0] len_mask;
    logic             at_end;

    always_comb begin
        case (mode_i.bl)
            3'b000:  len_mask = '0;
            3'b001:  len_mask = COL_W'(1);
            3'b010:  len_mask = COL_W'(3);
            3'b011:  len_mask = COL_W'(7);
            default: len_mask = '1;
        endcase
    end

    assign at_end = s_q.active && !s_q.full && (s_q.beat == s_q.mask);

    always_comb begin
        s_d = s_q;
        if (go_i) begin
            s_d.active = 1'b1;
            s_d.col    = go_col_i;
            s_d.beat   = '0;
            s_d.inter  = mode_i.interleave;
            if (go_write_i && mode_i.single_wr) begin
                s_d.mask = '0;
                s_d.full = 1'b0;
            end else begin
                s_d.mask = len_mask;
                s_d.full = (mode_i.bl == BL_PAGE);
            end
        end else if (stop_i) begin
            s_d.active = 1'b0;
        end else if (s_q.active) begin
            if (at_end) begin
                s_d.active = 1'b0;
            end else begin
                s_d.beat = s_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid_o      = s_q.active;
    assign last_o       = at_end;
    assign start_col_o  = s_q.col;
    assign beat_o       = s_q.beat;
    assign mask_o       = s_q.mask;
    assign interleave_o = s_q.inter;

    // R9
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !go_i) |=> !valid_o);

    // R11
    last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && last_o && !go_i) |=> !valid_o);

    // R11
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !go_i && !stop_i) |=>
            (valid_o && (beat_o == $past(beat_o) + COL_W'(1))));

    // R7
    single_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && go_write_i && mode_i.single_wr) |=> (valid_o && last_o));

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] start_col_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             interleave_i,
    output logic [COL_W-1:0] addr_o
);
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] seq_addr;
    logic [COL_W-1:0] ilv_addr;

    assign sum = start_col_i + beat_i;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign seq_addr[b] = mask_i[b] ? sum[b] : start_col_i[b];
        assign ilv_addr[b] = start_col_i[b] ^ beat_i[b];
    end

    assign addr_o = interleave_i ? ilv_addr : seq_addr;

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int OP_W  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_load,
    input  logic [OP_W-1:0]  mode_op,
    input  logic             cmd_start,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             burst_stop,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last,
    output logic [2:0]       cas_lat,
    output logic             single_write,
    output logic             mode_error
);
    mode_t            mode;
    logic [COL_W-1:0] start_col;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] mask;
    logic             interleave;

    colgen_mode_reg #(.OP_W(OP_W)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (mode_load),
        .op_i   (mode_op),
        .mode_o (mode),
        .err_o  (mode_error)
    );

    colgen_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode),
        .go_i         (cmd_start),
        .go_write_i   (cmd_write),
        .go_col_i     (cmd_col),
        .stop_i       (burst_stop),
        .valid_o      (col_valid),
        .last_o       (col_last),
        .start_col_o  (start_col),
        .beat_o       (beat),
        .mask_o       (mask),
        .interleave_o (interleave)
    );

    colgen_addr_map #(.COL_W(COL_W)) u_map (
        .start_col_i  (start_col),
        .beat_i       (beat),
        .mask_i       (mask),
        .interleave_i (interleave),
        .addr_o       (col_addr)
    );

    assign cas_lat      = mode.cas;
    assign single_write = mode.single_wr;

    // R3 R4
    block_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |-> (((col_addr ^ start_col) & ~mask) == '0));

    // R11
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (col_valid && (col_addr == $past(cmd_col))));

endmodule

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_load = 1'b0;
    logic [12:0] mode_op = '0;
    logic        cmd_start = 1'b0;
    logic        cmd_write = 1'b0;
    logic [9:0]  cmd_col = '0;
    logic        burst_stop = 1'b0;
    logic [9:0]  col_addr;
    logic        col_valid, col_last;
    logic [2:0]  cas_lat;
    logic        single_write, mode_error;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    sdram_burst_colgen uut (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_op(mode_op),
        .cmd_start(cmd_start), .cmd_write(cmd_write), .cmd_col(cmd_col),
        .burst_stop(burst_stop), .col_addr(col_addr), .col_valid(col_valid),
        .col_last(col_last), .cas_lat(cas_lat), .single_write(single_write),
        .mode_error(mode_error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [12:0] mk_op(input int bl, input int bt, input int cas, input int wm);
        return 13'((wm << 9) | (cas << 4) | (bt << 3) | bl);
    endfunction

    function automatic int exp_addr(input int col, input int k, input int len, input bit ilv);
        int base;
        if (ilv) return col ^ k;
        base = col - (col % len);
        return base + ((col % len) + k) % len;
    endfunction

    task automatic load_mode(input logic [12:0] op);
        @(negedge clk); mode_load = 1'b1; mode_op = op;
        @(negedge clk); mode_load = 1'b0;
    endtask

    // Starts a burst, checks n beats; if ends, expects last on beat n-1 then valid low.
    task automatic run_burst(input int col, input bit wr, input int n, input int len,
                             input bit ilv, input bit ends, input string req);
        @(negedge clk); cmd_start = 1'b1; cmd_col = 10'(col); cmd_write = wr;
        @(negedge clk); cmd_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            int e = exp_addr(col, k, len, ilv);
            chk(col_valid && col_addr == 10'(e), req, int'(col_addr), e);
            chk(col_last == (ends && k == n - 1), {req, " last"}, int'(col_last),
                int'(ends && k == n - 1));
            if (k < n - 1) @(negedge clk);
        end
        if (ends) begin
            @(negedge clk);
            chk(!col_valid, {req, " valid drop"}, int'(col_valid), 0);
        end
    endtask

    task automatic t_reset;
        chk(!col_valid, "R1 valid", int'(col_valid), 0);
        chk(cas_lat == 3'd3, "R1 cas", int'(cas_lat), 3);
        chk(!single_write, "R1 single_write", int'(single_write), 0);
        chk(!mode_error, "R1 mode_error", int'(mode_error), 0);
        run_burst(37, 0, 1, 1, 0, 1, "R1 default length");
    endtask

    task automatic t_lengths;
        load_mode(mk_op(1, 0, 3, 0)); run_burst(1023, 0, 2, 2, 0, 1, "R2 len2");
        load_mode(mk_op(2, 0, 3, 0)); run_burst(1, 0, 4, 4, 0, 1, "R3 len4 seq");
        load_mode(mk_op(3, 0, 3, 0)); run_burst(13, 0, 8, 8, 0, 1, "R3 len8 seq");
        chk(cas_lat == 3'd3, "R5 cas", int'(cas_lat), 3);
    endtask

    task automatic t_interleave;
        load_mode(mk_op(3, 1, 3, 0)); run_burst(5, 0, 8, 8, 1, 1, "R4 len8 ilv");
        load_mode(mk_op(2, 1, 3, 0)); run_burst(6, 0, 4, 4, 1, 1, "R4 len4 ilv");
    endtask

    task automatic t_reserved;
        load_mode(mk_op(2, 0, 3, 0));
        load_mode(mk_op(5, 0, 3, 0));
        chk(mode_error, "R6 bad length flag", int'(mode_error), 1);
        run_burst(1, 0, 4, 4, 0, 1, "R6 mode kept after bad length");
        load_mode(mk_op(3, 0, 2, 0));
        chk(cas_lat == 3'd3, "R6 cas kept", int'(cas_lat), 3);
        load_mode(mk_op(7, 1, 3, 0));
        run_burst(2, 0, 4, 4, 0, 1, "R6 mode kept after page+ilv");
        chk(mode_error, "R6 sticky", int'(mode_error), 1);
    endtask

    task automatic t_single_write;
        load_mode(mk_op(3, 0, 3, 1));
        chk(single_write, "R7 flag", int'(single_write), 1);
        run_burst(20, 1, 1, 1, 0, 1, "R7 write one beat");
        run_burst(20, 0, 8, 8, 0, 1, "R7 read full length");
    endtask

    task automatic t_full_page;
        load_mode(mk_op(7, 0, 3, 0));
        run_burst(1020, 0, 10, 1024, 0, 0, "R8 page wrap");
        burst_stop = 1'b1;
        @(negedge clk); burst_stop = 1'b0;
        chk(!col_valid, "R9 stop", int'(col_valid), 0);
        burst_stop = 1'b1;
        @(negedge clk); burst_stop = 1'b0;
        chk(!col_valid, "R9 stop idle", int'(col_valid), 0);
    endtask

    task automatic t_interrupt;
        load_mode(mk_op(3, 0, 3, 0));
        run_burst(0, 0, 3, 8, 0, 0, "R10 first burst");
        run_burst(100, 0, 8, 8, 0, 1, "R10 restart");
        run_burst(40, 0, 2, 8, 0, 0, "R9 pre");
        burst_stop = 1'b1; cmd_start = 1'b1; cmd_col = 10'd200; cmd_write = 1'b0;
        @(negedge clk); burst_stop = 1'b0; cmd_start = 1'b0;
        chk(col_valid && col_addr == 10'd200, "R9 start beats stop", int'(col_addr), 200);
        chk(!col_last, "R9 start beats stop last", int'(col_last), 0);
    endtask

    task automatic t_mode_midburst;
        load_mode(mk_op(3, 0, 3, 0));
        @(negedge clk); cmd_start = 1'b1; cmd_col = 10'd16; cmd_write = 1'b0;
        @(negedge clk); cmd_start = 1'b0; mode_load = 1'b1; mode_op = mk_op(1, 0, 3, 0);
        for (int k = 0; k < 8; k++) begin
            chk(col_valid && col_addr == 10'(16 + k), "R12 burst kept", int'(col_addr), 16 + k);
            chk(col_last == (k == 7), "R12 last", int'(col_last), int'(k == 7));
            @(negedge clk); mode_load = 1'b0;
        end
        chk(!col_valid, "R12 end", int'(col_valid), 0);
        run_burst(9, 0, 2, 2, 0, 1, "R12 new mode next burst");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lengths();
        t_interleave();
        t_reserved();
        t_single_write();
        t_full_page();
        t_interrupt();
        t_mode_midburst();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule